// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer

A 16-bit counter with a byte-wide register port and three working modes. As a pulse-width generator it drives a square wave whose high and low lengths are programmed separately, counted in prescaled clock ticks. In capture mode it records the running count when a selected edge arrives on either of two capture inputs. In event mode it advances on edges of an external input instead of the clock, and it keeps the same high/low phase behaviour.

Software configures it with writes to a small address space and observes it through a registered read port. The two compare values are called the high-time register and the low-time register. A capture on the second input overwrites the low-time register. Status flags for capture and for the end of a low phase feed a single interrupt request output. A dedicated write address clears the counter.

Top module: `mmt_timer16`

## Requirements
- R1: In pulse mode (mode field = 01) `pwm_out` is high for H ticks and low for L ticks and repeats this without end. H is the high-time register and L is the low-time register. A value of 0 acts as 1.
- R2: Bits [4:2] of the mode register (address 0x06 read, 0x16 write) select the tick rate. One tick occurs every 2^sel clock cycles in pulse and capture modes.
- R3: In capture mode (mode field = 10) an active edge on `cap1_in` stores the count into the capture register (reads 0x00 low, 0x01 high) and sets status bit 6. A later edge overwrites the stored value.
- R4: In capture mode an active edge on `cap2_in` stores the count into the low-time register and sets status bit 7.
- R5: Mode register bit 6 selects the active edge of the capture and event inputs: 1 means rising and 0 means falling. The other edge has no effect.
- R6: In event mode (mode field = 11) ticks come only from active edges on `evt_in`. The clock and the prescaler do not advance the counter.
- R7: With mode field 00 the counter holds its value and `pwm_out` is low.
- R8: A write to address 0x10 sets the counter and the prescaler to zero and starts a high phase.
- R9: The end of each low phase in pulse or event mode sets status bit 4.
- R10: Byte writes go to 0x14/0x15 (high-time low/high byte), 0x12/0x13 (low-time low/high byte), 0x16 (mode register) and 0x17 (status/enable register). Reads of 0x04/0x05, 0x02/0x03, 0x06 and 0x07 return these registers.
- R11: A write to the status/enable register (0x17) loads all its bits, so writing zero clears the pending flags. A flag set by hardware in the same cycle wins.
- R12: `irq` is high one cycle after (bit 2 and bit 4) or (bit 5 and (bit 6 or bit 7)) holds in the status/enable register.
- R13: After reset all registers are zero and `pwm_out`, `irq` and `bus_rdata` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| cap1_in | input | 1 | Capture input 1, asynchronous |
| cap2_in | input | 1 | Capture input 2, asynchronous |
| evt_in | input | 1 | External event input, asynchronous |
| pwm_out | output | 1 | Pulse output, registered |
| irq | output | 1 | Interrupt request, registered |

## Verification
A register write takes effect at the next clock edge, and its read data appears on `bus_rdata` one edge after the address is presented. An edge on an external input is acted on two edges after it changes, and `pwm_out` and `irq` follow one edge after that. The bench therefore waits several cycles before it samples these outputs, and it samples on the falling clock. Pulse lengths are measured between consecutive transitions of `pwm_out`, so the fixed latency drops out. Captured values are compared as differences between two captures, because both inputs pass through the same path.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_PWM  = 2'b01,
    MODE_CAPT = 2'b10,
    MODE_EVT  = 2'b11
  } mmt_mode_e;

  // read map
  localparam logic [4:0] ADR_CAP_L = 5'h00;
  localparam logic [4:0] ADR_CAP_H = 5'h01;
  localparam logic [4:0] ADR_LO_L  = 5'h02;
  localparam logic [4:0] ADR_LO_H  = 5'h03;
  localparam logic [4:0] ADR_HI_L  = 5'h04;
  localparam logic [4:0] ADR_HI_H  = 5'h05;
  localparam logic [4:0] ADR_MODE  = 5'h06;
  localparam logic [4:0] ADR_STAT  = 5'h07;
  // write map
  localparam logic [4:0] ADR_CLR    = 5'h10;
  localparam logic [4:0] ADR_LO_L_W = 5'h12;
  localparam logic [4:0] ADR_LO_H_W = 5'h13;
  localparam logic [4:0] ADR_HI_L_W = 5'h14;
  localparam logic [4:0] ADR_HI_H_W = 5'h15;
  localparam logic [4:0] ADR_MODE_W = 5'h16;
  localparam logic [4:0] ADR_STAT_W = 5'h17;

  // bit positions
  localparam int MB_EDGE   = 6;
  localparam int MB_PS_LSB = 2;
  localparam int SB_CMP_IE = 2;
  localparam int SB_LOEND  = 4;
  localparam int SB_CAP_IE = 5;
  localparam int SB_CAP1   = 6;
  localparam int SB_CAP2   = 7;

endpackage

// File: rtl/mmt_edge_det.sv
module mmt_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic rise_sel,
  output logic hit
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  logic now_v, old_v;
  always_comb begin
    now_v = sh_q[STAGES-1];
    old_v = sh_q[STAGES];
    hit   = rise_sel ? (now_v & ~old_v) : (~now_v & old_v);
  end
endmodule

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            clr,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = ~({DIV_W{1'b1}} << sel);
    tick = run & ((div_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else if (run)   div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/mmt_phase_counter.sv
module mmt_phase_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             phased,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  output logic [CNT_W-1:0] cnt,
  output logic             phase_hi,
  output logic             low_end
);
  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   nxt;
  logic             done;

  always_comb begin
    lim     = ph_q ? hi_len : lo_len;
    nxt     = {1'b0, cnt_q} + 1'b1;
    done    = (nxt >= {1'b0, lim});
    low_end = tick & phased & ~ph_q & done & ~clr;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (tick) begin
      if (phased && done) begin
        cnt_q <= '0;
        ph_q  <= ~ph_q;
      end else begin
        cnt_q <= nxt[CNT_W-1:0];
      end
    end
  end

  assign cnt      = cnt_q;
  assign phase_hi = ph_q;
endmodule

// File: rtl/mmt_timer16.sv
module mmt_timer16
  import mmt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 5,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cap1_in,
  input  logic              cap2_in,
  input  logic              evt_in,
  output logic              pwm_out,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int N_IN  = 3;

  logic [DATA_W-1:0] ctl_a_q, ctl_a_d, ctl_b_q, rdata_q, rd_mux;
  logic [CNT_W-1:0]  hi_q, lo_q, cap_q, cnt_q;
  logic              pwm_q, irq_q;
  mmt_mode_e         mode;

  always_comb mode = mmt_mode_e'(ctl_b_q[1:0]);

  // address decode
  logic wr_clr, wr_hi, wr_lo, wr_mode, wr_stat;
  always_comb begin
    wr_clr  = bus_wr && (bus_addr == ADDR_W'(ADR_CLR));
    wr_lo   = bus_wr && (bus_addr == ADDR_W'(ADR_LO_L_W) || bus_addr == ADDR_W'(ADR_LO_H_W));
    wr_hi   = bus_wr && (bus_addr == ADDR_W'(ADR_HI_L_W) || bus_addr == ADDR_W'(ADR_HI_H_W));
    wr_mode = bus_wr && (bus_addr == ADDR_W'(ADR_MODE_W));
    wr_stat = bus_wr && (bus_addr == ADDR_W'(ADR_STAT_W));
  end

  // input conditioning: 0 = cap1, 1 = cap2, 2 = event
  logic [N_IN-1:0] raw_in, hit;
  always_comb raw_in = {evt_in, cap2_in, cap1_in};

  generate
    for (genvar g = 0; g < N_IN; g++) begin : g_edge
      mmt_edge_det #(.STAGES(SYNC_STAGES)) u_det (
        .clk      (clk),
        .rst      (rst),
        .din      (raw_in[g]),
        .rise_sel (ctl_b_q[MB_EDGE]),
        .hit      (hit[g])
      );
    end
  endgenerate

  // tick source
  logic ps_run, ps_tick, tick, phased, phase_hi, low_end;
  logic cap1_evt, cap2_evt;
  always_comb begin
    ps_run   = (mode == MODE_PWM) || (mode == MODE_CAPT);
    phased   = (mode == MODE_PWM) || (mode == MODE_EVT);
    tick     = (mode == MODE_EVT) ? hit[2] : ps_tick;
    cap1_evt = (mode == MODE_CAPT) && hit[0];
    cap2_evt = (mode == MODE_CAPT) && hit[1];
  end

  mmt_prescaler #(.PS_W(PS_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (ps_run),
    .clr  (wr_clr),
    .sel  (ctl_b_q[MB_PS_LSB +: PS_W]),
    .tick (ps_tick)
  );

  mmt_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (wr_clr),
    .tick     (tick),
    .phased   (phased),
    .hi_len   (hi_q),
    .lo_len   (lo_q),
    .cnt      (cnt_q),
    .phase_hi (phase_hi),
    .low_end  (low_end)
  );

  // compare / capture registers
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      cap_q <= '0;
    end else begin
      if (wr_hi) begin
        if (bus_addr[0]) hi_q[CNT_W-1:DATA_W] <= bus_wdata;
        else             hi_q[DATA_W-1:0]     <= bus_wdata;
      end
      if (cap2_evt) lo_q <= cnt_q;
      else if (wr_lo) begin
        if (bus_addr[0]) lo_q[CNT_W-1:DATA_W] <= bus_wdata;
        else             lo_q[DATA_W-1:0]     <= bus_wdata;
      end
      if (cap1_evt) cap_q <= cnt_q;
    end
  end

  // status / enable register
  always_comb begin
    ctl_a_d = ctl_a_q;
    if (wr_stat)  ctl_a_d = bus_wdata;
    if (low_end)  ctl_a_d[SB_LOEND] = 1'b1;
    if (cap1_evt) ctl_a_d[SB_CAP1]  = 1'b1;
    if (cap2_evt) ctl_a_d[SB_CAP2]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_a_q <= '0;
      ctl_b_q <= '0;
    end else begin
      ctl_a_q <= ctl_a_d;
      if (wr_mode) ctl_b_q <= bus_wdata;
    end
  end

  // read port
  always_comb begin
    case (bus_addr)
      ADDR_W'(ADR_CAP_L): rd_mux = cap_q[DATA_W-1:0];
      ADDR_W'(ADR_CAP_H): rd_mux = cap_q[CNT_W-1:DATA_W];
      ADDR_W'(ADR_LO_L):  rd_mux = lo_q[DATA_W-1:0];
      ADDR_W'(ADR_LO_H):  rd_mux = lo_q[CNT_W-1:DATA_W];
      ADDR_W'(ADR_HI_L):  rd_mux = hi_q[DATA_W-1:0];
      ADDR_W'(ADR_HI_H):  rd_mux = hi_q[CNT_W-1:DATA_W];
      ADDR_W'(ADR_MODE):  rd_mux = ctl_b_q;
      ADDR_W'(ADR_STAT):  rd_mux = ctl_a_q;
      default:            rd_mux = '0;
    endcase
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      pwm_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_mux;
      pwm_q   <= phase_hi & phased;
      irq_q   <= (ctl_a_q[SB_CMP_IE] & ctl_a_q[SB_LOEND]) |
                 (ctl_a_q[SB_CAP_IE] & (ctl_a_q[SB_CAP1] | ctl_a_q[SB_CAP2]));
    end
  end

  assign bus_rdata = rdata_q;
  assign pwm_out   = pwm_q;
  assign irq       = irq_q;
endmodule

// File: rtl/mmt_timer16_chk.sv
module mmt_timer16_chk
  import mmt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   ctl_a,
  input logic [DATA_W-1:0]   ctl_b,
  input logic [2*DATA_W-1:0] cnt,
  input logic                pwm_out,
  input logic                irq
);
  // R7
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_b[1:0] == 2'b00 && !(bus_wr && bus_addr == ADDR_W'(ADR_CLR))) |=> $stable(cnt));

  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_b[1:0] == 2'b00) |=> !pwm_out);

  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(ADR_CLR)) |=> (cnt == '0));

  // R11
  stat_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(ADR_STAT_W) && bus_wdata == '0 && ctl_b[1:0] == 2'b00)
    |=> (ctl_a == '0));

  // R12
  irq_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_a[SB_CAP_IE] && ctl_a[SB_CAP1]) |=> irq);

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_a[SB_CMP_IE] && !ctl_a[SB_CAP_IE]) |=> !irq);

  // R3
  cap1_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_a[SB_CAP1]) |->
      ($past(ctl_b[1:0]) == 2'b10 || $past(bus_wr && bus_addr == ADDR_W'(ADR_STAT_W))));
endmodule

bind mmt_timer16 mmt_timer16_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .ctl_a     (ctl_a_q),
  .ctl_b     (ctl_b_q),
  .cnt       (cnt_q),
  .pwm_out   (pwm_out),
  .irq       (irq)
);

// File: tb/test_mmt_timer16.sv
`timescale 1ns/1ps
module test_mmt_timer16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap1_in = 1'b0, cap2_in = 1'b0, evt_in = 1'b0;
  logic       pwm_out, irq;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  mmt_timer16 i_mmt_timer16 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap1_in(cap1_in),
    .cap2_in(cap2_in), .evt_in(evt_in), .pwm_out(pwm_out), .irq(irq)
  );

  // PWM vectors: high reg, low reg, prescale select, expected high/low cycles
  localparam int NV = 5;
  localparam int V_HI [NV] = '{3, 1, 0, 2, 5};
  localparam int V_LO [NV] = '{2, 1, 4, 3, 1};
  localparam int V_PS [NV] = '{0, 0, 0, 1, 2};
  localparam int E_HI [NV] = '{3, 1, 1, 4, 20};
  localparam int E_LO [NV] = '{2, 1, 4, 6, 4};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic rd16(input logic [4:0] a, output int v);
    int lo, hi;
    rd(a, lo);
    rd(a + 5'd1, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic wait_level(input logic lvl);
    for (int n = 0; n < 4000 && pwm_out !== lvl; n++) @(negedge clk);
  endtask

  task automatic run_len(input logic lvl, output int len);
    len = 0;
    while (pwm_out === lvl && len < 4000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic ev_pulse();
    evt_in = 1'b1; repeat (4) @(negedge clk);
    evt_in = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    int v, v2, hl, ll;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R13 reset state
    chk("R13 pwm_out", int'(pwm_out), 0);
    chk("R13 irq", int'(irq), 0);
    rd(5'h07, v); chk("R13 status reg", v, 0);
    rd(5'h04, v); chk("R13 high-time reg", v, 0);

    // R10 register map
    wr(5'h15, 8'h12); wr(5'h14, 8'h34);
    wr(5'h13, 8'h56); wr(5'h12, 8'h78);
    wr(5'h16, 8'h1C);
    rd(5'h05, v); chk("R10 high-time hi byte", v, 'h12);
    rd(5'h04, v); chk("R10 high-time lo byte", v, 'h34);
    rd(5'h03, v); chk("R10 low-time hi byte", v, 'h56);
    rd(5'h02, v); chk("R10 low-time lo byte", v, 'h78);
    rd(5'h06, v); chk("R10 mode reg", v, 'h1C);

    // R1 / R2 table of PWM settings
    for (int i = 0; i < NV; i++) begin
      wr(5'h16, 8'h00);
      wr(5'h15, 8'((V_HI[i] >> 8) & 'hFF)); wr(5'h14, 8'(V_HI[i] & 'hFF));
      wr(5'h13, 8'((V_LO[i] >> 8) & 'hFF)); wr(5'h12, 8'(V_LO[i] & 'hFF));
      wr(5'h10, 8'h00);
      wr(5'h16, 8'(8'h01 | (V_PS[i] << 2)));
      wait_level(1'b0);
      wait_level(1'b1);
      run_len(1'b1, hl);
      run_len(1'b0, ll);
      chk((V_PS[i] != 0) ? "R2 prescaled high length" : "R1 high length", hl, E_HI[i]);
      chk((V_PS[i] != 0) ? "R2 prescaled low length"  : "R1 low length",  ll, E_LO[i]);
    end

    // R7 disabled mode drives low
    wr(5'h16, 8'h00);
    repeat (3) @(negedge clk);
    chk("R7 pwm_out low when off", int'(pwm_out), 0);

    // R3 / R4 capture, rising edge
    wr(5'h17, 8'h20);
    wr(5'h16, 8'h42);
    wr(5'h10, 8'h00);
    repeat (2) @(negedge clk);
    cap1_in = 1'b1;
    repeat (10) @(negedge clk);
    cap2_in = 1'b1;
    repeat (8) @(negedge clk);
    rd16(5'h00, v);
    rd16(5'h02, v2);
    chk("R4 capture2 minus capture1", (v2 - v) & 'hFFFF, 10);
    rd(5'h07, v);
    chk("R3 capture1 flag", (v >> 6) & 1, 1);
    chk("R4 capture2 flag", (v >> 7) & 1, 1);
    chk("R12 irq on capture", int'(irq), 1);
    cap1_in = 1'b0;
    repeat (3) @(negedge clk);
    cap1_in = 1'b1;
    repeat (6) @(negedge clk);
    rd16(5'h00, v);
    chk("R3 later capture overwrites", (v - v2) & 'hFFFF, 16);

    // R11 clearing flags by write
    wr(5'h17, 8'h20);
    repeat (3) @(negedge clk);
    chk("R11 irq drops after clear", int'(irq), 0);
    rd(5'h07, v); chk("R11 status after write", v, 'h20);

    // R5 inactive edge ignored, then falling edge selected
    cap1_in = 1'b0;
    repeat (6) @(negedge clk);
    rd(5'h07, v); chk("R5 falling edge ignored", v, 'h20);
    wr(5'h16, 8'h02);
    cap2_in = 1'b0;
    repeat (6) @(negedge clk);
    rd(5'h07, v); chk("R5 falling edge captures", (v >> 7) & 1, 1);
    wr(5'h17, 8'h00);

    // R6 / R9 event mode
    wr(5'h16, 8'h00);
    wr(5'h15, 8'h00); wr(5'h14, 8'h02);
    wr(5'h13, 8'h00); wr(5'h12, 8'h03);
    wr(5'h10, 8'h00);
    wr(5'h17, 8'h04);
    wr(5'h16, 8'h43);
    repeat (40) @(negedge clk);
    chk("R6 no clock ticks in event mode", int'(pwm_out), 1);
    ev_pulse();
    chk("R6 one event stays high", int'(pwm_out), 1);
    ev_pulse();
    chk("R6 second event ends high phase", int'(pwm_out), 0);
    ev_pulse(); ev_pulse();
    chk("R6 low phase continues", int'(pwm_out), 0);
    rd(5'h07, v); chk("R9 no flag mid low phase", (v >> 4) & 1, 0);
    ev_pulse();
    chk("R6 low phase ends", int'(pwm_out), 1);
    rd(5'h07, v); chk("R9 end-of-low flag", (v >> 4) & 1, 1);
    chk("R12 compare irq", int'(irq), 1);

    // R8 clear restarts the phase
    ev_pulse();
    wr(5'h10, 8'h00);
    ev_pulse();
    chk("R8 clear restarts count", int'(pwm_out), 1);
    ev_pulse();
    chk("R8 phase ends after full count", int'(pwm_out), 0);

    done_flag = 1'b1;
    report();
  end
endmodule